// File: doc/BRIEF.md
# Nested Fragment/Block/Transaction DMA Address Sequencer

This block is the address and count engine of a single DMA channel. The work is split into three nested levels. A transaction is cut into blocks, and each block is cut into fragments. Every level has its own byte length. The engine issues one beat per element on a simple valid/ready memory port. Each beat carries a source address, a destination address and the two element sizes. The source and destination addresses advance after every accepted beat, each by its own step. Either side can instead be held fixed.

One request (from a hardware line or a software strobe) lets the engine run until it reaches the level chosen by a 2-bit mode: one fragment, one block, or the rest of the transaction. After that the engine parks and waits for the next request. A level-sensitive pause input stops the engine after the beat in flight, and the engine confirms the stop on a separate acknowledge output. Dropping the channel enable abandons the transaction.

The configuration is sampled when a transaction starts. Progress can be followed through a destination-address output that is always valid.

Top module: `hier_dma_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `mem_valid`, `pause_ack`, all four done pulses and `cur_dst_addr` are 0.
- R2: While `chan_en` is 0, requests are ignored. If `chan_en` is 0 at a clock edge, `mem_valid` is 0 after that edge and the transaction is abandoned. A beat accepted at that same edge still counts.
- R3: `mem_src_size` and `mem_dst_size` carry the 2-bit width codes from `frag_word[31:30]` and `frag_word[29:28]`. Code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. Each accepted beat consumes 2^code bytes of the source width from every length counter.
- R4: The first beat of a transaction uses `src_base` and `dst_base`. After each accepted beat, the source address grows by `step_word[15:0]` and the destination address grows by `step_word[31:16]`.
- R5: When `frag_word[20]` is 1, one side is held at its base address. If `frag_word[21]` is 1 the destination is held and the source still steps. If `frag_word[21]` is 0 the source is held.
- R6: `frag_done` pulses in the cycle after the beat that exhausts the fragment length (`frag_word[16:0]`, bytes). It also pulses after a beat that ends a block. The fragment count restarts at every block boundary.
- R7: `blk_done` pulses in the cycle after the beat that exhausts the block length (`blk_len`, bytes). It also pulses after the beat that ends the transaction, so a short final block is truncated.
- R8: `trsc_done` pulses in the cycle after the beat that exhausts the transaction length (`trsc_len`, bytes). A length of 0 means one block. The engine then goes idle, and the next request restarts from the base addresses with a freshly sampled configuration.
- R9: The mode field `frag_word[25:24]` selects what one request covers: 0 means a fragment, 1 a block, 2 the transaction, and 3 is treated like 2. Events have levels fragment=1, block=2, transaction=3. `req_done` pulses with the first event whose level is at least the mode plus one. After it, no beat is offered until a new request arrives.
- R10: While `pause_req` is 1, no beat is offered once the beat in flight has been accepted. `pause_ack` is 1 from the following cycle until `pause_req` falls. Requests are ignored while `pause_ack` is 1.
- R11: A beat that is offered but not accepted stays offered with unchanged addresses until it is accepted, unless `chan_en` falls.
- R12: `cur_dst_addr` always equals the destination address of the next beat to be issued.
- R13: Requests that arrive while the engine is issuing beats are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| frag_word | input | 32 | Widths [31:28], mode [25:24], fix select [21], fix enable [20], fragment bytes [16:0] |
| blk_len | input | 17 | Block length in bytes |
| trsc_len | input | TLEN_W | Transaction length in bytes, 0 = one block |
| step_word | input | 32 | Destination step [31:16], source step [15:0] |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| hw_req | input | 1 | Hardware request |
| sw_req | input | 1 | Software request strobe |
| pause_req | input | 1 | Pause request, level |
| pause_ack | output | 1 | Engine is paused |
| mem_valid | output | 1 | Beat offered |
| mem_ready | input | 1 | Beat accepted |
| mem_src_addr | output | AW | Beat source address |
| mem_dst_addr | output | AW | Beat destination address |
| mem_src_size | output | 2 | Source element width code |
| mem_dst_size | output | 2 | Destination element width code |
| frag_done | output | 1 | Fragment finished pulse |
| blk_done | output | 1 | Block finished pulse |
| trsc_done | output | 1 | Transaction finished pulse |
| req_done | output | 1 | Request's work finished pulse |
| cur_dst_addr | output | AW | Destination address of the next beat |

## Verification
The bound checker watches the local rules on every cycle:
- a stalled beat holds its addresses;
- enable low or pause acknowledged silences the port;
- the done pulses nest (transaction implies block implies fragment);
- a done pulse follows an accepted beat;
- the engine is quiet after a request completes.

Where the boundaries fall, which addresses are produced, how fixed sides and truncated last blocks and fragments behave, and whether a restart picks up the base addresses can only be shown by the bench. It compares the design against a byte-position model across several widths, modes, stall patterns, pauses and enable drops.

// File: rtl/hds_pkg.sv
package hds_pkg;

  localparam int unsigned FLEN_W = 17;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } hds_state_e;

  typedef struct packed {
    logic [1:0]        src_w;
    logic [1:0]        dst_w;
    logic [1:0]        mode;
    logic              fix_en;
    logic              fix_sel;
    logic [FLEN_W-1:0] frag_len;
    logic [FLEN_W-1:0] blk_len;
    logic [15:0]       src_step;
    logic [15:0]       dst_step;
  } hds_cfg_t;

  // bytes consumed by one beat for a width code
  function automatic logic [3:0] beat_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // event level a request mode waits for; the list mode behaves as transaction
  function automatic logic [1:0] need_level(input logic [1:0] mode);
    return (mode == 2'd3) ? 2'd3 : mode + 2'd1;
  endfunction

endpackage

// File: rtl/hds_level_cnt.sv
module hds_level_cnt #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_len,
  input  logic [W-1:0] reload_len,
  input  logic         fire,
  input  logic [3:0]   beat,
  input  logic         upper_end,
  output logic         last
);

  localparam int unsigned PAD = W - 4;

  logic [W-1:0] rem_q;
  logic [W-1:0] rem_d;
  logic [W-1:0] beat_ext;
  logic         cnt_en;

  assign beat_ext = {{PAD{1'b0}}, beat};
  assign last     = (rem_q <= beat_ext) || upper_end;
  assign cnt_en   = load || fire;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = load_len;
    end else if (fire) begin
      rem_d = last ? reload_len : rem_q - beat_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (cnt_en) begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/hds_addr_gen.sv
module hds_addr_gen #(
  parameter int unsigned AW     = 32,
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     base,
  input  logic              fire,
  input  logic [STEP_W-1:0] step,
  input  logic              hold,
  output logic [AW-1:0]     addr
);

  localparam int unsigned PAD = AW - STEP_W;

  logic [AW-1:0] addr_d;
  logic [AW-1:0] inc;
  logic          addr_en;

  assign inc     = hold ? '0 : {{PAD{1'b0}}, step};
  assign addr_en = load || fire;

  always_comb begin
    addr_d = addr;
    if (load) begin
      addr_d = base;
    end else if (fire) begin
      addr_d = addr + inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (addr_en) begin
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/hds_ctrl.sv
module hds_ctrl
  import hds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic req,
  input  logic pause_req,
  input  logic mem_ready,
  input  logic t_last,
  input  logic req_hit,
  output logic start,
  output logic fire,
  output logic mem_valid,
  output logic paused
);

  hds_state_e state_q;
  hds_state_e state_d;
  logic       paused_d;
  logic       accept;

  assign mem_valid = (state_q == ST_RUN) && !paused;
  assign fire      = mem_valid && mem_ready;
  assign accept    = chan_en && req && !paused && (state_q != ST_RUN);
  assign start     = accept && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    if (!chan_en) begin
      state_d = ST_IDLE;
    end else if (accept) begin
      state_d = ST_RUN;
    end else if (fire) begin
      if (t_last) begin
        state_d = ST_IDLE;
      end else if (req_hit) begin
        state_d = ST_ARMED;
      end
    end
  end

  // a pause is granted only between beats
  assign paused_d = pause_req && (paused || (state_q != ST_RUN) || fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      paused  <= 1'b0;
    end else begin
      state_q <= state_d;
      paused  <= paused_d;
    end
  end

endmodule

// File: rtl/hier_dma_seq.sv
module hier_dma_seq
  import hds_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned TLEN_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [31:0]       frag_word,
  input  logic [FLEN_W-1:0] blk_len,
  input  logic [TLEN_W-1:0] trsc_len,
  input  logic [31:0]       step_word,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic              hw_req,
  input  logic              sw_req,
  input  logic              pause_req,
  output logic              pause_ack,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_src_addr,
  output logic [AW-1:0]     mem_dst_addr,
  output logic [1:0]        mem_src_size,
  output logic [1:0]        mem_dst_size,
  output logic              frag_done,
  output logic              blk_done,
  output logic              trsc_done,
  output logic              req_done,
  output logic [AW-1:0]     cur_dst_addr
);

  localparam int unsigned STEP_W = 16;
  localparam int unsigned TPAD   = TLEN_W - FLEN_W;
  localparam int unsigned NSIDE  = 2;

  hds_cfg_t          cfg_q;
  hds_cfg_t          cfg_in;
  logic              start;
  logic              fire;
  logic              f_last;
  logic              b_last;
  logic              t_last;
  logic              req_hit;
  logic [1:0]        evt_lvl;
  logic [3:0]        beat;
  logic [TLEN_W-1:0] trsc_eff;
  logic [3:0]        done_d;
  logic [3:0]        done_q;
  logic              cfg_unused;

  assign cfg_unused = ^{frag_word[27:26], frag_word[23:22], frag_word[19:17]};

  // configuration fields sampled at transaction start
  always_comb begin
    cfg_in          = '0;
    cfg_in.src_w    = frag_word[31:30];
    cfg_in.dst_w    = frag_word[29:28];
    cfg_in.mode     = frag_word[25:24];
    cfg_in.fix_sel  = frag_word[21];
    cfg_in.fix_en   = frag_word[20];
    cfg_in.frag_len = frag_word[FLEN_W-1:0];
    cfg_in.blk_len  = blk_len;
    cfg_in.dst_step = step_word[31:16];
    cfg_in.src_step = step_word[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (start) begin
      cfg_q <= cfg_in;
    end
  end

  assign trsc_eff = (trsc_len == '0) ? {{TPAD{1'b0}}, blk_len} : trsc_len;
  assign beat     = beat_bytes(cfg_q.src_w);

  hds_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .req       (hw_req | sw_req),
    .pause_req (pause_req),
    .mem_ready (mem_ready),
    .t_last    (t_last),
    .req_hit   (req_hit),
    .start     (start),
    .fire      (fire),
    .mem_valid (mem_valid),
    .paused    (pause_ack)
  );

  hds_level_cnt #(.W(TLEN_W)) u_trsc_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_len   (trsc_eff),
    .reload_len ('0),
    .fire       (fire),
    .beat       (beat),
    .upper_end  (1'b0),
    .last       (t_last)
  );

  hds_level_cnt #(.W(FLEN_W)) u_blk_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_len   (cfg_in.blk_len),
    .reload_len (cfg_q.blk_len),
    .fire       (fire),
    .beat       (beat),
    .upper_end  (t_last),
    .last       (b_last)
  );

  hds_level_cnt #(.W(FLEN_W)) u_frag_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_len   (cfg_in.frag_len),
    .reload_len (cfg_q.frag_len),
    .fire       (fire),
    .beat       (beat),
    .upper_end  (b_last),
    .last       (f_last)
  );

  // address generators: index 0 = source, 1 = destination
  logic [AW-1:0]     side_base [NSIDE];
  logic [STEP_W-1:0] side_step [NSIDE];
  logic              side_hold [NSIDE];
  logic [AW-1:0]     side_addr [NSIDE];

  assign side_base[0] = src_base;
  assign side_base[1] = dst_base;
  assign side_step[0] = cfg_q.src_step;
  assign side_step[1] = cfg_q.dst_step;
  assign side_hold[0] = cfg_q.fix_en && !cfg_q.fix_sel;
  assign side_hold[1] = cfg_q.fix_en && cfg_q.fix_sel;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    hds_addr_gen #(.AW(AW), .STEP_W(STEP_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .base  (side_base[g]),
      .fire  (fire),
      .step  (side_step[g]),
      .hold  (side_hold[g]),
      .addr  (side_addr[g])
    );
  end

  assign mem_src_addr = side_addr[0];
  assign mem_dst_addr = side_addr[1];
  assign cur_dst_addr = side_addr[1];
  assign mem_src_size = cfg_q.src_w;
  assign mem_dst_size = cfg_q.dst_w;

  // completion level of the beat now being accepted
  always_comb begin
    if (t_last)      evt_lvl = 2'd3;
    else if (b_last) evt_lvl = 2'd2;
    else if (f_last) evt_lvl = 2'd1;
    else             evt_lvl = 2'd0;
  end

  assign req_hit = fire && (evt_lvl != 2'd0) && (evt_lvl >= need_level(cfg_q.mode));

  assign done_d = {req_hit, fire && t_last, fire && b_last, fire && f_last};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      done_q <= done_d;
    end
  end

  assign frag_done = done_q[0];
  assign blk_done  = done_q[1];
  assign trsc_done = done_q[2];
  assign req_done  = done_q[3];

endmodule

// File: rtl/hds_chk.sv
module hds_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          pause_ack,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_src_addr,
  input logic [AW-1:0] mem_dst_addr,
  input logic          frag_done,
  input logic          blk_done,
  input logic          trsc_done,
  input logic          req_done
);

  // R2
  enable_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !mem_valid);

  // R10
  paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ack |-> !mem_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && chan_en) |=>
      (mem_valid && $stable(mem_src_addr) && $stable(mem_dst_addr)));

  // R6
  frag_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> $past(mem_valid && mem_ready));

  // R7
  blk_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> frag_done);

  // R8
  trsc_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trsc_done |-> (blk_done && req_done && !mem_valid));

  // R9
  req_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (frag_done && !mem_valid));

endmodule

bind hier_dma_seq hds_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_hier_dma_seq.sv
`timescale 1ns/1ps
module test_hier_dma_seq;

  localparam int AW = 32;
  localparam int TW = 28;

  logic          clk;
  logic          rst_n;
  logic          chan_en;
  logic [31:0]   frag_word;
  logic [16:0]   blk_len;
  logic [TW-1:0] trsc_len;
  logic [31:0]   step_word;
  logic [AW-1:0] src_base;
  logic [AW-1:0] dst_base;
  logic          hw_req;
  logic          sw_req;
  logic          pause_req;
  logic          pause_ack;
  logic          mem_valid;
  logic          mem_ready;
  logic [AW-1:0] mem_src_addr;
  logic [AW-1:0] mem_dst_addr;
  logic [1:0]    mem_src_size;
  logic [1:0]    mem_dst_size;
  logic          frag_done;
  logic          blk_done;
  logic          trsc_done;
  logic          req_done;
  logic [AW-1:0] cur_dst_addr;

  hier_dma_seq #(.AW(AW), .TLEN_W(TW)) i_hier_dma_seq (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk;
  int n_bad;
  bit finished;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (byte-position view) ----------------
  int          m_state;   // 0 idle, 1 waiting, 2 running
  bit          m_paused;
  int          m_pos;
  int          m_T, m_B, m_F, m_beat, m_mode;
  int          m_srcw, m_dstw;
  bit          m_hold_src, m_hold_dst;
  int          m_sstep, m_dstep;
  logic [31:0] m_src, m_dst;
  bit          m_f, m_b, m_t, m_r;
  int          m_tcnt, m_rcnt;
  bit          stall_seen;
  logic [31:0] stall_src, stall_dst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_paused = 0; m_pos = 0; m_src = 0; m_dst = 0;
      m_f = 0; m_b = 0; m_t = 0; m_r = 0; m_tcnt = 0; m_rcnt = 0;
      m_srcw = 0; m_dstw = 0; m_T = 1; m_B = 1; m_F = 1; m_beat = 1;
      m_mode = 0; m_hold_src = 0; m_hold_dst = 0; m_sstep = 0; m_dstep = 0;
      stall_seen = 0;
    end else begin
      bit valid, took, acc, np;
      int lvl, need;
      valid = (m_state == 2) && !m_paused;
      took  = valid && mem_ready;
      stall_seen = valid && !mem_ready && chan_en;
      stall_src = m_src; stall_dst = m_dst;
      m_f = 0; m_b = 0; m_t = 0; m_r = 0;
      if (took) begin
        m_pos += m_beat;
        m_t = (m_pos >= m_T);
        m_b = ((m_pos % m_B) == 0) || m_t;
        m_f = (((m_pos % m_B) % m_F) == 0) || m_b;
        if (!m_hold_src) m_src = m_src + m_sstep;
        if (!m_hold_dst) m_dst = m_dst + m_dstep;
        lvl  = m_t ? 3 : (m_b ? 2 : (m_f ? 1 : 0));
        need = (m_mode == 3) ? 3 : m_mode + 1;
        m_r  = (lvl > 0) && (lvl >= need);
        if (m_t) m_tcnt++;
        if (m_r) m_rcnt++;
      end
      acc = chan_en && !m_paused && (hw_req || sw_req) && (m_state != 2);
      if (!pause_req)     np = 0;
      else if (m_paused)  np = 1;
      else if (valid && !took) np = 0;
      else np = 1;
      if (!chan_en) m_state = 0;
      else if (acc) begin
        if (m_state == 0) begin
          m_srcw = frag_word[31:30]; m_dstw = frag_word[29:28];
          m_mode = frag_word[25:24];
          m_hold_dst = frag_word[20] && frag_word[21];
          m_hold_src = frag_word[20] && !frag_word[21];
          m_F = frag_word[16:0]; m_B = blk_len;
          m_T = (trsc_len == 0) ? blk_len : trsc_len;
          m_beat = 1 << m_srcw;
          m_sstep = step_word[15:0]; m_dstep = step_word[31:16];
          m_src = src_base; m_dst = dst_base; m_pos = 0;
        end
        m_state = 2;
      end else if (took) begin
        if (m_t) m_state = 0;
        else if (m_r) m_state = 1;
      end
      m_paused = np;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit mv;
      mv = (m_state == 2) && !m_paused;
      check("R9 mem_valid", mem_valid, mv);
      if (mv) begin
        check("R4 src addr", mem_src_addr, m_src);
        check("R4 dst addr", mem_dst_addr, m_dst);
        check("R3 src size", mem_src_size, m_srcw);
        check("R3 dst size", mem_dst_size, m_dstw);
      end
      check("R6 frag_done", frag_done, m_f);
      check("R7 blk_done", blk_done, m_b);
      check("R8 trsc_done", trsc_done, m_t);
      check("R9 req_done", req_done, m_r);
      check("R10 pause_ack", pause_ack, m_paused);
      check("R12 cur_dst_addr", cur_dst_addr, m_dst);
      if (stall_seen) begin
        check("R11 stall valid", mem_valid, 1'b1);
        check("R11 stall src", mem_src_addr, stall_src);
        check("R11 stall dst", mem_dst_addr, stall_dst);
      end
    end
  end

  // ---------------- memory ready pattern ----------------
  bit        rand_rdy;
  logic [7:0] lfsr;
  always @(negedge clk) begin
    if (!rst_n) lfsr <= 8'hA5;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= rand_rdy ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(input int sw, input int dw, input int mode, input bit fen,
                         input bit fsel, input int frag, input int blk, input int trsc,
                         input int sstep, input int dstep, input logic [31:0] sb,
                         input logic [31:0] db);
    frag_word = '0;
    frag_word[31:30] = sw[1:0];
    frag_word[29:28] = dw[1:0];
    frag_word[25:24] = mode[1:0];
    frag_word[21] = fsel;
    frag_word[20] = fen;
    frag_word[16:0] = frag[16:0];
    blk_len = blk[16:0];
    trsc_len = trsc[TW-1:0];
    step_word = {dstep[15:0], sstep[15:0]};
    src_base = sb;
    dst_base = db;
  endtask

  task automatic pulse(input bit hw);
    @(negedge clk);
    if (hw) hw_req = 1'b1; else sw_req = 1'b1;
    @(negedge clk);
    hw_req = 1'b0; sw_req = 1'b0;
  endtask

  task automatic wait_trsc();
    int c0;
    c0 = m_tcnt;
    for (int i = 0; i < 2000 && m_tcnt == c0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_req();
    int c0;
    c0 = m_rcnt;
    for (int i = 0; i < 2000 && m_rcnt == c0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(150000 * 10);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL R9 watchdog expired act=1 exp=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 1'b0; chan_en = 1'b0; hw_req = 1'b0; sw_req = 1'b0;
    pause_req = 1'b0; rand_rdy = 1'b0; mem_ready = 1'b1;
    set_cfg(0, 0, 0, 0, 0, 4, 4, 4, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mem_valid", mem_valid, 0);
    check("R1 pause_ack", pause_ack, 0);
    check("R1 done pulses", {frag_done, blk_done, trsc_done, req_done}, 0);
    check("R1 cur_dst_addr", cur_dst_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle idle", mem_valid, 0);

    // R2: requests ignored while disabled
    set_cfg(2, 2, 2, 0, 0, 8, 16, 40, 4, 4, 32'h1000, 32'h8000);
    pulse(0);
    repeat (4) @(negedge clk);
    check("R2 disabled no beat", mem_valid, 0);
    check("R2 disabled dst untouched", cur_dst_addr, 0);

    // R7 R8: transaction mode with truncated last block, then restart
    chan_en = 1'b1;
    pulse(0);
    wait_trsc();
    check("R8 final dst", cur_dst_addr, 32'h8000 + 40);
    set_cfg(2, 1, 2, 0, 0, 8, 16, 40, 4, 8, 32'h2000, 32'h9000);
    pulse(1);
    wait_trsc();
    check("R8 restart final dst", cur_dst_addr, 32'h9000 + 80);

    // R9 R13: fragment mode, extra request while running
    set_cfg(1, 1, 0, 0, 0, 4, 8, 16, 2, 2, 32'h3000, 32'hA000);
    pulse(1);
    hw_req = 1'b1;            // R13 request during the running fragment
    @(negedge clk);
    hw_req = 1'b0;
    wait_req();
    repeat (3) @(negedge clk);
    check("R13 parked after one fragment", mem_valid, 0);
    check("R13 one fragment of progress", cur_dst_addr, 32'hA000 + 4);
    for (int k = 0; k < 3; k++) begin
      pulse(k[0]);
      wait_req();
    end
    check("R9 four fragments end transaction", cur_dst_addr, 32'hA000 + 16);

    // R6: block mode, zero transaction length, truncated fragment
    set_cfg(0, 0, 1, 0, 0, 4, 6, 0, 1, 2, 32'h4000, 32'hB000);
    pulse(0);
    wait_trsc();
    check("R6 one block only", cur_dst_addr, 32'hB000 + 12);

    // R5: fixed destination, list mode behaves as transaction
    set_cfg(2, 2, 3, 1, 1, 8, 8, 24, 4, 4, 32'h5000, 32'hC000);
    pulse(0);
    wait_trsc();
    check("R5 destination held", cur_dst_addr, 32'hC000);
    set_cfg(2, 2, 3, 1, 0, 8, 8, 24, 4, 4, 32'h5000, 32'hC000);
    pulse(1);
    wait_trsc();
    check("R5 destination steps with source held", cur_dst_addr, 32'hC000 + 24);

    // R10 R11: random ready, pauses, 8-byte beats
    rand_rdy = 1'b1;
    set_cfg(3, 3, 2, 0, 0, 16, 32, 128, 8, 8, 32'h6000, 32'hD000);
    pulse(0);
    repeat (5) @(negedge clk);
    pause_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 paused", pause_ack, 1);
    pulse(0);                  // ignored while paused
    pause_req = 1'b0;
    repeat (7) @(negedge clk);
    pause_req = 1'b1;
    repeat (4) @(negedge clk);
    pause_req = 1'b0;
    wait_trsc();
    check("R10 full transaction after pauses", cur_dst_addr, 32'hD000 + 128);
    rand_rdy = 1'b0;

    // R2: enable drop mid transaction, then restart
    set_cfg(2, 2, 2, 0, 0, 8, 16, 64, 4, 4, 32'h7000, 32'hE000);
    pulse(0);
    repeat (3) @(negedge clk);
    chan_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 enable drop stops beats", mem_valid, 0);
    chan_en = 1'b1;
    pulse(1);
    wait_trsc();
    check("R2 restart from base", cur_dst_addr, 32'hE000 + 64);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule